// File: doc/BRIEF.md
# Serial Write Transmitter for a Graphic LCD Controller

This block sends bytes to a monochrome graphic LCD controller that accepts writes only. An upstream sequencer offers one byte at a time, together with a flag that says whether the byte is a command or pixel data. The offer uses a valid/ready handshake. The block drives an active-low chip select and a serial clock, and shifts the byte out most-significant bit first. A separate register-select line tells the panel how to treat the byte. The panel samples that line at the last bit of the byte, so the line acts like a ninth bit. The block has no receive path, and the serial input pin from the panel is ignored.

The parameter `HALF_DIV` sets each half of the serial clock period in system clocks. `CPOL_IDLE` picks whether the serial clock rests low or high. With either setting, the data bit is stable across each low-to-high transition, which is where the panel latches it. The block drives a one-cycle `done` pulse one system clock after chip select returns high, and `in_ready` is already high in that cycle. A sequencer can therefore chain commands and data with no extra gap.

Top module: `lcd_serial_tx`

## Requirements
- R1: During and right after reset: `cs_n`=1, `rs`=1, `in_ready`=1, `busy`=0 and `done`=0.
- R2: Each accepted byte makes exactly 8 low-to-high transitions of `sclk` while `cs_n` is low. `mosi` is stable across each transition and carries the byte most-significant bit first.
- R3: `rs` is 0 for a byte offered with `in_is_data`=0 (command) and 1 for `in_is_data`=1 (display data). It holds that value, unchanged, for the whole time `cs_n` is low, and it is 1 whenever `cs_n` is high.
- R4: The first rising edge of `sclk` comes `HALF_DIV` system clocks after `cs_n` falls. After that, `sclk` changes level every `HALF_DIV` system clocks.
- R5: `cs_n` falls on the clock edge that accepts a byte (`in_valid` and `in_ready` both high). It stays low for exactly 16*`HALF_DIV` system clocks.
- R6: While a byte is in flight, `in_ready` is 0 and `busy` is 1. An `in_valid` raised in that time starts no transfer and does not alter the byte being sent.
- R7: `done` is a single-cycle pulse, one system clock after `cs_n` rises. A byte offered in the `done` cycle is accepted at once, so `cs_n` stays high for exactly 2 system clocks between back-to-back bytes.
- R8: Whenever `cs_n` is high, `sclk` rests at the level given by `CPOL_IDLE` (0 = low, 1 = high). A transfer ends with `sclk` back at that level.
- R9: The `miso` input has no effect on `mosi` or on the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers a byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_byte | input | DATA_W | Byte to send |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| miso | input | 1 | Serial input from panel, ignored |
| sclk | output | 1 | Serial clock to panel |
| mosi | output | 1 | Serial data to panel, MSB first |
| cs_n | output | 1 | Active-low chip select |
| rs | output | 1 | Register select: 0 command, 1 data |
| busy | output | 1 | Byte in flight |
| done | output | 1 | One-cycle pulse after a byte completes |

## Verification
Take the accepting edge as cycle 0. `cs_n` falls in cycle 0, and the first `sclk` rise is due in cycle `HALF_DIV`. `cs_n` rises in cycle 16*`HALF_DIV`, and `done` is due one cycle later. A monitor samples every output on the falling system-clock edge, half a cycle away from the edges where the outputs move. It counts low chip-select cycles and rising serial edges, so each of these delays is compared as an exact count. The monitor also latches `rs` and `mosi` at each rising serial edge, the moment the panel itself samples them. The bench reads these results one time unit after the `done` sample, before it offers the next byte.

// File: rtl/lcdtx_pkg.sv
package lcdtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FIN   = 2'd2
  } tx_state_e;

  // System clocks during which chip select is low for one byte.
  function automatic int unsigned frame_cycles(int unsigned half_div,
                                               int unsigned nbits);
    return 2 * half_div * nbits;
  endfunction

  // Width of a counter that indexes nbits positions.
  function automatic int unsigned idx_width(int unsigned nbits);
    return (nbits > 1) ? $clog2(nbits) : 1;
  endfunction

endpackage

// File: rtl/lcdtx_halfper.sv
// Produces one tick per serial half period while a frame runs.
module lcdtx_halfper #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick
);

  generate
    if (HALF_DIV <= 1) begin : g_every
      assign half_tick = run;
    end else begin : g_count
      localparam int unsigned CW = $clog2(HALF_DIV);
      localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
      logic [CW-1:0] cnt;

      assign half_tick = run && (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (!run || half_tick) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lcdtx_engine.sv
// Frame sequencer: accepts a byte, shifts it MSB first, closes the frame.
module lcdtx_engine
  import lcdtx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CPOL_IDLE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_is_data,
  input  logic              half_tick,
  output logic              in_ready,
  output logic              run,
  output logic              accept,
  output logic              frame_end,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              rs,
  output logic              busy,
  output logic              done
);

  localparam int unsigned   BW       = idx_width(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);
  localparam logic          IDLE_LVL = (CPOL_IDLE != 0);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bit_idx;
  logic              phase_hi;
  logic              rs_q;
  logic              done_q;
  logic              in_frame;

  assign in_frame  = (state == ST_SHIFT);
  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign frame_end = in_frame && half_tick && phase_hi && (bit_idx == LAST_BIT);
  assign run       = in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bit_idx  <= '0;
      phase_hi <= 1'b0;
      rs_q     <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          if (accept) begin
            shreg    <= in_byte;
            rs_q     <= in_is_data;
            bit_idx  <= '0;
            phase_hi <= 1'b0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (half_tick) begin
            if (!phase_hi) begin
              phase_hi <= 1'b1;
            end else if (frame_end) begin
              state <= ST_FIN;
            end else begin
              phase_hi <= 1'b0;
              bit_idx  <= bit_idx + 1'b1;
              shreg    <= {shreg[DATA_W-2:0], 1'b0};
            end
          end
        end
        ST_FIN: begin
          rs_q  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_n = !in_frame;
  assign rs   = in_frame ? rs_q : 1'b1;
  assign sclk = in_frame ? phase_hi : IDLE_LVL;
  assign mosi = in_frame ? shreg[DATA_W-1] : 1'b0;
  assign busy = !in_ready;
  assign done = done_q;

endmodule

// File: rtl/lcd_serial_tx.sv
module lcd_serial_tx #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned CPOL_IDLE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_is_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              rs,
  output logic              busy,
  output logic              done
);

  // Internal events, named for the bound checker.
  logic half_tick;
  logic run;
  logic accept;
  logic frame_end;

  lcdtx_halfper #(
    .HALF_DIV (HALF_DIV)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .half_tick (half_tick)
  );

  lcdtx_engine #(
    .DATA_W    (DATA_W),
    .CPOL_IDLE (CPOL_IDLE)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_is_data (in_is_data),
    .half_tick  (half_tick),
    .in_ready   (in_ready),
    .run        (run),
    .accept     (accept),
    .frame_end  (frame_end),
    .sclk       (sclk),
    .mosi       (mosi),
    .cs_n       (cs_n),
    .rs         (rs),
    .busy       (busy),
    .done       (done)
  );

endmodule

// File: rtl/lcd_serial_tx_chk.sv
module lcd_serial_tx_chk #(
  parameter int unsigned CPOL_IDLE = 0
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic miso,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic rs,
  input logic busy,
  input logic done,
  input logic half_tick,
  input logic accept,
  input logic frame_end
);

  localparam logic IDLE_LVL = (CPOL_IDLE != 0);

  p_accept_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !cs_n);

  p_accept_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!cs_n && !in_ready));

  p_rs_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> rs);

  p_rs_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(rs));

  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == IDLE_LVL));

  p_mosi_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(sclk)) |-> $stable(mosi));

  p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (busy && !in_ready));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(cs_n) && !$past(cs_n, 2)));

  p_frame_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cs_n && !done));

  p_tick_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> !cs_n);

  p_miso_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$past(half_tick) && !$stable(miso))
      |-> $stable(mosi));

endmodule

bind lcd_serial_tx lcd_serial_tx_chk #(
  .CPOL_IDLE (CPOL_IDLE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .miso      (miso),
  .sclk      (sclk),
  .mosi      (mosi),
  .cs_n      (cs_n),
  .rs        (rs),
  .busy      (busy),
  .done      (done),
  .half_tick (half_tick),
  .accept    (accept),
  .frame_end (frame_end)
);

// File: tb/sim_lcd_serial_tx.sv
// Passive monitor: samples on the falling system-clock edge.
module sim_lcd_serial_tx_mon (
  input  logic       clk,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       cs_n,
  input  logic       rs,
  input  logic       done,
  output logic [7:0] cap,
  output logic       cap_rs,
  output int         rises,
  output int         cs_len,
  output int         first_rise,
  output int         hi_gap,
  output int         done_gap,
  output int         nbytes
);
  int   cyc = 0;
  int   hi_run = 0;
  int   cs_rise_at = 0;
  logic pcs = 1'b1;
  logic psclk = 1'b1;

  initial begin
    cap = '0; cap_rs = 1'b1; rises = 0; cs_len = 0; first_rise = 0;
    hi_gap = 0; done_gap = 0; nbytes = 0;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!cs_n) begin
      if (pcs) begin
        rises = 0; cs_len = 0; first_rise = 0; hi_gap = hi_run;
      end
      cs_len = cs_len + 1;
      if (sclk && !psclk) begin
        cap    = {cap[6:0], mosi};
        cap_rs = rs;
        rises  = rises + 1;
        if (rises == 1) first_rise = cs_len;
      end
      hi_run = 0;
    end else begin
      hi_run = hi_run + 1;
      if (!pcs) begin
        cs_rise_at = cyc;
        nbytes = nbytes + 1;
      end
    end
    if (done) done_gap = cyc - cs_rise_at;
    pcs   = cs_n;
    psclk = sclk;
  end
endmodule

module sim_lcd_serial_tx;
  localparam int DIV = 3;
  localparam int WDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       v0 = 0, f0 = 0, v1 = 0, f1 = 0;
  logic [7:0] b0 = 0, b1 = 0;
  logic       miso = 0, miso_tog = 0;
  logic       rdy0, sclk0, mosi0, csn0, rs0, busy0, done0;
  logic       rdy1, sclk1, mosi1, csn1, rs1, busy1, done1;

  always @(posedge clk) if (miso_tog) miso <= ~miso;

  lcd_serial_tx #(.DATA_W(8), .HALF_DIV(DIV), .CPOL_IDLE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_ready(rdy0), .in_byte(b0),
    .in_is_data(f0), .miso(miso), .sclk(sclk0), .mosi(mosi0), .cs_n(csn0),
    .rs(rs0), .busy(busy0), .done(done0));

  lcd_serial_tx #(.DATA_W(8), .HALF_DIV(DIV), .CPOL_IDLE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(rdy1), .in_byte(b1),
    .in_is_data(f1), .miso(miso), .sclk(sclk1), .mosi(mosi1), .cs_n(csn1),
    .rs(rs1), .busy(busy1), .done(done1));

  logic [7:0] cap0, cap1;
  logic       crs0, crs1;
  int rises0, cslen0, first0, gap0, dgap0, nb0;
  int rises1, cslen1, first1, gap1, dgap1, nb1;

  sim_lcd_serial_tx_mon m0 (.clk(clk), .sclk(sclk0), .mosi(mosi0), .cs_n(csn0),
    .rs(rs0), .done(done0), .cap(cap0), .cap_rs(crs0), .rises(rises0),
    .cs_len(cslen0), .first_rise(first0), .hi_gap(gap0), .done_gap(dgap0),
    .nbytes(nb0));
  sim_lcd_serial_tx_mon m1 (.clk(clk), .sclk(sclk1), .mosi(mosi1), .cs_n(csn1),
    .rs(rs1), .done(done1), .cap(cap1), .cap_rs(crs1), .rises(rises1),
    .cs_len(cslen1), .first_rise(first1), .hi_gap(gap1), .done_gap(dgap1),
    .nbytes(nb1));

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // {in_is_data, byte}
  localparam logic [8:0] VEC [6] = '{9'h0A2, 9'h1F0, 9'h081, 9'h100, 9'h1FF, 9'h05A};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // Offer a byte at a falling edge, wait for acceptance and for done.
  task automatic send(input int which, input logic [7:0] b, input logic f);
    if (which == 0) begin v0 = 1; b0 = b; f0 = f; end
    else begin v1 = 1; b1 = b; f1 = f; end
    forever begin
      if ((which == 0) ? rdy0 : rdy1) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    if (which == 0) v0 = 0; else v1 = 0;
    while (!((which == 0) ? done0 : done1)) @(negedge clk);
    #1;
  endtask

  initial begin
    // Reset: R1, R8
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", csn0, 1);
    chk("R1 rs in reset", rs0, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cs_n", csn0, 1);
    chk("R1 rs", rs0, 1);
    chk("R1 in_ready", rdy0, 1);
    chk("R1 busy", busy0, 0);
    chk("R1 done", done0, 0);
    chk("R8 sclk idle low", sclk0, 0);
    chk("R8 sclk idle high", sclk1, 1);

    // Table walk on u0, back to back.
    foreach (VEC[i]) begin
      send(0, VEC[i][7:0], VEC[i][8]);
      chk("R2 byte MSB first", cap0, VEC[i][7:0]);
      chk("R2 rising edges", rises0, 8);
      chk("R3 rs at last bit", crs0, VEC[i][8]);
      chk("R4 first rise delay", first0, DIV + 1);
      chk("R5 cs_n low length", cslen0, 8 * 2 * DIV);
      chk("R7 done after cs_n", dgap0, 1);
      if (i > 0) chk("R7 gap between bytes", gap0, 2);
    end
    chk("R8 sclk back low", sclk0, 0);
    chk("R3 rs idle high", rs0, 1);

    // R6: offer ignored while a byte is in flight.
    begin
      int nb_before;
      repeat (4) @(negedge clk);
      nb_before = nb0;
      v0 = 1; b0 = 8'h3C; f0 = 1'b0;
      @(posedge clk); @(negedge clk);
      b0 = 8'hC3; f0 = 1'b1;
      repeat (5) @(negedge clk);
      chk("R6 ready low in flight", rdy0, 0);
      chk("R6 busy in flight", busy0, 1);
      repeat (5) @(negedge clk);
      v0 = 0;
      while (!done0) @(negedge clk);
      #1;
      chk("R6 byte unchanged", cap0, 8'h3C);
      chk("R6 rs unchanged", crs0, 0);
      repeat (20) @(negedge clk);
      chk("R6 no extra transfer", nb0, nb_before + 1);
      chk("R6 cs_n stays high", csn0, 1);
    end

    // R9: miso toggling during a transfer.
    miso_tog = 1;
    send(0, 8'h96, 1'b1);
    miso_tog = 0;
    chk("R9 byte with miso toggling", cap0, 8'h96);

    // R8: idle-high instance.
    send(1, 8'hA5, 1'b1);
    chk("R8 idle-high byte", cap1, 8'hA5);
    chk("R8 idle-high edges", rises1, 8);
    chk("R8 idle-high first rise", first1, DIV + 1);
    chk("R8 idle-high rs", crs1, 1);
    chk("R8 sclk back high", sclk1, 1);
    send(1, 8'h01, 1'b0);
    chk("R8 idle-high command byte", cap1, 8'h01);
    chk("R3 idle-high command rs", crs1, 0);
    chk("R7 idle-high done gap", dgap1, 1);

    summary();
    $finish;
  end
endmodule